// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a bus-mapped watchdog that escalates in two steps. Software programs a 48-bit timeout offset and sets an enable bit. Each explicit refresh then loads a 64-bit compare value with the current system count plus the offset. The count is a free-running 64-bit input. If the count reaches the compare value without a refresh, the block raises a level interrupt and re-arms for another full offset period. If that second deadline also passes, the block raises a reset request.

Two 32-bit register frames, each with its own simple bus port, give access to the block. The refresh frame holds only a keep-alive register and an identity word. The control frame holds the control/status word, the two offset words, the two compare words and the identity word. A bad access in either frame raises that frame's error flag in the same cycle and changes nothing.

The core is a four-state machine:
- `ST_OFF`: disabled.
- `ST_ARMED`: waiting for the first deadline.
- `ST_WARNED`: the interrupt is raised and the machine waits for the second deadline.
- `ST_FIRED`: the reset request is raised.

The transitions are:
- enable (`ST_OFF`→`ST_ARMED`, on a control write with bit 0 set);
- disable (any state→`ST_OFF`);
- refresh (any enabled state→`ST_ARMED`);
- first expiry (`ST_ARMED`→`ST_WARNED`);
- second expiry (`ST_WARNED`→`ST_FIRED`).

Top module: `wdg_top`

## Requirements
- R1: After reset, the offset, compare and status values read as zero, `irq` and `rst_req` are low, and the identity word at offset 0x0FC reads `ID_VALUE` (default 0x57440A01).
- R2: A write to the control word (control offset 0x000) stores only data bit 0 as the enable. It clears both status flags, drops `irq` and performs an explicit refresh. A read of it returns enable in bit 0, the first-stage flag in bit 1 and the second-stage flag in bit 2, with zero elsewhere.
- R3: The offset is 48 bits. The low word (control offset 0x008) supplies bits 31:0, and data bits 15:0 of the high word (control offset 0x00C) supply bits 47:32. High-word writes keep only those 16 bits.
- R4: An explicit refresh loads the compare value with the system count plus the offset, but only while enabled. The compare words (control offsets 0x010 low, 0x014 high) are readable, and writable with no other effect.
- R5: A write of any value to the keep-alive register (refresh offset 0x000) clears both status flags and performs an explicit refresh. A read of it returns zero and has no effect.
- R6: A write to either offset word clears both status flags, drops `irq` and performs an explicit refresh using the new offset.
- R7: While armed and with the first-stage flag clear, a count at or above the compare value sets the first-stage flag and raises `irq`. It also reloads the compare value with the count plus the offset.
- R8: While the first-stage flag is set, a count at or above the compare value sets the second-stage flag and raises `rst_req`. `rst_req` never rises unless `irq` was already high.
- R9: The identity word reads the same constant from both frames at offset 0x0FC.
- R10: An address whose two low bits are not zero, or an undefined offset, raises that frame's error output in the same cycle. Such an access has no effect and reads zero.
- R11: While disabled, no deadline is checked and both status flags, `irq` and `rst_req` stay low.
- R12: `irq` stays high until a refresh, control write or offset write clears it. A bus write in the same cycle as a deadline takes priority over the deadline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_cnt | input | 64 | Free-running system count |
| rf_sel | input | 1 | Refresh frame access valid |
| rf_wr | input | 1 | Refresh frame write (1) or read (0) |
| rf_addr | input | 12 | Refresh frame byte offset |
| rf_wdata | input | 32 | Refresh frame write data |
| rf_rdata | output | 32 | Refresh frame read data (combinational) |
| rf_err | output | 1 | Refresh frame bad access |
| cf_sel | input | 1 | Control frame access valid |
| cf_wr | input | 1 | Control frame write (1) or read (0) |
| cf_addr | input | 12 | Control frame byte offset |
| cf_wdata | input | 32 | Control frame write data |
| cf_rdata | output | 32 | Control frame read data (combinational) |
| cf_err | output | 1 | Control frame bad access |
| irq | output | 1 | First-stage interrupt, level |
| rst_req | output | 1 | Second-stage reset request, level |

## Verification
Read data and error flags are combinational, so they are due in the same cycle as the access. The bench samples them 1 ns after driving the access, before the clock edge. Register writes, refreshes and deadline crossings all act at the next rising edge, and `irq` and `rst_req` are decoded from the state register. Those outputs are therefore sampled at the falling edge that follows that rising edge, with the system count held constant across each access.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_ARMED  = 2'd1,
        ST_WARNED = 2'd2,
        ST_FIRED  = 2'd3
    } wdg_state_t;

    typedef enum logic [2:0] {
        RS_NONE, RS_CTRL, RS_OFFLO, RS_OFFHI, RS_CMPLO, RS_CMPHI, RS_ID, RS_ZERO
    } wdg_rsel_t;

    localparam int OFS_CTRL  = 'h000;
    localparam int OFS_OFFLO = 'h008;
    localparam int OFS_OFFHI = 'h00C;
    localparam int OFS_CMPLO = 'h010;
    localparam int OFS_CMPHI = 'h014;
    localparam int OFS_ID    = 'h0FC;
    localparam int OFS_KICK  = 'h000;
endpackage

// File: rtl/wdg_ctrl_dec.sv
module wdg_ctrl_dec
    import wdg_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    output logic          err,
    output wdg_rsel_t     rsel,
    output logic          wr_ctrl,
    output logic          wr_offlo,
    output logic          wr_offhi,
    output logic          wr_cmplo,
    output logic          wr_cmphi
);
    localparam logic [AW-1:0] A_CTRL  = AW'(OFS_CTRL);
    localparam logic [AW-1:0] A_OFFLO = AW'(OFS_OFFLO);
    localparam logic [AW-1:0] A_OFFHI = AW'(OFS_OFFHI);
    localparam logic [AW-1:0] A_CMPLO = AW'(OFS_CMPLO);
    localparam logic [AW-1:0] A_CMPHI = AW'(OFS_CMPHI);
    localparam logic [AW-1:0] A_ID    = AW'(OFS_ID);

    wdg_rsel_t hit;
    logic      ok;

    always_comb begin
        if (addr == A_CTRL)       hit = RS_CTRL;
        else if (addr == A_OFFLO) hit = RS_OFFLO;
        else if (addr == A_OFFHI) hit = RS_OFFHI;
        else if (addr == A_CMPLO) hit = RS_CMPLO;
        else if (addr == A_CMPHI) hit = RS_CMPHI;
        else if (addr == A_ID)    hit = RS_ID;
        else                      hit = RS_NONE;
        err      = sel && ((|addr[1:0]) || hit == RS_NONE);
        ok       = sel && !err;
        rsel     = (ok && !wr) ? hit : RS_NONE;
        wr_ctrl  = ok && wr && hit == RS_CTRL;
        wr_offlo = ok && wr && hit == RS_OFFLO;
        wr_offhi = ok && wr && hit == RS_OFFHI;
        wr_cmplo = ok && wr && hit == RS_CMPLO;
        wr_cmphi = ok && wr && hit == RS_CMPHI;
    end

    AST_CF_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !(wr_ctrl || wr_offlo || wr_offhi || wr_cmplo || wr_cmphi)); // R10
    AST_CF_ERR_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> rsel == RS_NONE); // R10
endmodule

// File: rtl/wdg_kick_dec.sv
module wdg_kick_dec
    import wdg_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    output logic          err,
    output wdg_rsel_t     rsel,
    output logic          kick
);
    localparam logic [AW-1:0] A_KICK = AW'(OFS_KICK);
    localparam logic [AW-1:0] A_ID   = AW'(OFS_ID);

    wdg_rsel_t hit;

    always_comb begin
        if (addr == A_KICK)    hit = RS_ZERO;
        else if (addr == A_ID) hit = RS_ID;
        else                   hit = RS_NONE;
        err  = sel && ((|addr[1:0]) || hit == RS_NONE);
        rsel = (sel && !err && !wr) ? hit : RS_NONE;
        kick = sel && !err && wr && hit == RS_ZERO;
    end

    AST_RF_ERR_NO_KICK: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !kick); // R10
endmodule

// File: rtl/wdg_core.sv
module wdg_core
    import wdg_pkg::*;
#(
    parameter int CW = 64,
    parameter int OW = 48
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] sys_cnt,
    input  logic [31:0]   wdata,
    input  logic          wr_ctrl,
    input  logic          wr_offlo,
    input  logic          wr_offhi,
    input  logic          wr_cmplo,
    input  logic          wr_cmphi,
    input  logic          kick,
    output logic          en,
    output logic          ws0,
    output logic          ws1,
    output logic [OW-1:0] offset,
    output logic [CW-1:0] cmp,
    output logic          irq,
    output logic          rst_req
);
    localparam int HIW = OW - 32;
    localparam int CHW = CW - 32;

    wdg_state_t     st, st_n;
    logic [31:0]    off_lo, lo_n;
    logic [HIW-1:0] off_hi, hi_n;
    logic [CW-1:0]  cmp_n;
    logic           explicit_rf, en_after, due;

    assign offset = {off_hi, off_lo};

    always_comb begin
        st_n        = st;
        cmp_n       = cmp;
        lo_n        = wr_offlo ? wdata : off_lo;
        hi_n        = wr_offhi ? wdata[HIW-1:0] : off_hi;
        explicit_rf = wr_ctrl || wr_offlo || wr_offhi || kick;
        en_after    = wr_ctrl ? wdata[0] : (st != ST_OFF);
        due         = (st != ST_OFF) && (sys_cnt >= cmp);
        if (explicit_rf) begin
            if (en_after) begin
                st_n  = ST_ARMED;
                cmp_n = sys_cnt + CW'({hi_n, lo_n});
            end else begin
                st_n  = ST_OFF;
            end
        end else if (wr_cmplo || wr_cmphi) begin
            if (wr_cmplo) cmp_n[31:0]    = wdata;
            if (wr_cmphi) cmp_n[CW-1:32] = wdata[CHW-1:0];
        end else if (due) begin
            unique case (st)
                ST_ARMED: begin
                    st_n  = ST_WARNED;
                    cmp_n = sys_cnt + CW'(offset);
                end
                ST_WARNED: st_n = ST_FIRED;
                default:   st_n = st;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_OFF;
            cmp    <= '0;
            off_lo <= '0;
            off_hi <= '0;
        end else begin
            st     <= st_n;
            cmp    <= cmp_n;
            off_lo <= lo_n;
            off_hi <= hi_n;
        end
    end

    always_comb begin
        unique case (st)
            ST_OFF:    begin en = 1'b0; ws0 = 1'b0; ws1 = 1'b0; end
            ST_ARMED:  begin en = 1'b1; ws0 = 1'b0; ws1 = 1'b0; end
            ST_WARNED: begin en = 1'b1; ws0 = 1'b1; ws1 = 1'b0; end
            ST_FIRED:  begin en = 1'b1; ws0 = 1'b1; ws1 = 1'b1; end
            default:   begin en = 1'b0; ws0 = 1'b0; ws1 = 1'b0; end
        endcase
        irq     = ws0;
        rst_req = ws1;
    end

    AST_RST_AFTER_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(irq)); // R8
    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !(wr_ctrl || wr_offlo || wr_offhi || kick) |=> irq); // R12
    AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl && !wdata[0] |=> !irq && !rst_req && !en); // R11
    AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !irq && !rst_req); // R5
    AST_OFFSET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_offlo || wr_offhi |=> !irq); // R6
endmodule

// File: rtl/wdg_top.sv
module wdg_top
    import wdg_pkg::*;
#(
    parameter int          AW       = 12,
    parameter int          CW       = 64,
    parameter int          OW       = 48,
    parameter logic [31:0] ID_VALUE = 32'h5744_0A01
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] sys_cnt,
    input  logic          rf_sel,
    input  logic          rf_wr,
    input  logic [AW-1:0] rf_addr,
    input  logic [31:0]   rf_wdata,
    output logic [31:0]   rf_rdata,
    output logic          rf_err,
    input  logic          cf_sel,
    input  logic          cf_wr,
    input  logic [AW-1:0] cf_addr,
    input  logic [31:0]   cf_wdata,
    output logic [31:0]   cf_rdata,
    output logic          cf_err,
    output logic          irq,
    output logic          rst_req
);
    wdg_rsel_t     cf_rsel, rf_rsel;
    logic          wr_ctrl, wr_offlo, wr_offhi, wr_cmplo, wr_cmphi, kick;
    logic          en, ws0, ws1;
    logic [OW-1:0] offset;
    logic [CW-1:0] cmp;
    logic          unused_rf_data;

    assign unused_rf_data = ^rf_wdata;

    wdg_ctrl_dec #(.AW(AW)) u_cdec (
        .clk(clk), .rst_n(rst_n), .sel(cf_sel), .wr(cf_wr), .addr(cf_addr),
        .err(cf_err), .rsel(cf_rsel), .wr_ctrl(wr_ctrl), .wr_offlo(wr_offlo),
        .wr_offhi(wr_offhi), .wr_cmplo(wr_cmplo), .wr_cmphi(wr_cmphi)
    );

    wdg_kick_dec #(.AW(AW)) u_kdec (
        .clk(clk), .rst_n(rst_n), .sel(rf_sel), .wr(rf_wr), .addr(rf_addr),
        .err(rf_err), .rsel(rf_rsel), .kick(kick)
    );

    wdg_core #(.CW(CW), .OW(OW)) u_core (
        .clk(clk), .rst_n(rst_n), .sys_cnt(sys_cnt), .wdata(cf_wdata),
        .wr_ctrl(wr_ctrl), .wr_offlo(wr_offlo), .wr_offhi(wr_offhi),
        .wr_cmplo(wr_cmplo), .wr_cmphi(wr_cmphi), .kick(kick),
        .en(en), .ws0(ws0), .ws1(ws1), .offset(offset), .cmp(cmp),
        .irq(irq), .rst_req(rst_req)
    );

    function automatic logic [31:0] rd_mux(wdg_rsel_t s);
        unique case (s)
            RS_CTRL:  rd_mux = {29'd0, ws1, ws0, en};
            RS_OFFLO: rd_mux = offset[31:0];
            RS_OFFHI: rd_mux = 32'(offset[OW-1:32]);
            RS_CMPLO: rd_mux = cmp[31:0];
            RS_CMPHI: rd_mux = cmp[CW-1:32];
            RS_ID:    rd_mux = ID_VALUE;
            default:  rd_mux = 32'd0;
        endcase
    endfunction

    assign cf_rdata = rd_mux(cf_rsel);
    assign rf_rdata = rd_mux(rf_rsel);

    AST_ERR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cf_err |-> cf_rdata == 32'd0); // R10
endmodule

// File: tb/wdg_top_tb.sv
module wdg_top_tb;
    localparam logic [31:0] ID = 32'h5744_0A01;

    typedef struct packed {
        logic        cf;
        logic        wr;
        logic [11:0] addr;
        logic [31:0] data;
        logic [63:0] cnt;
        logic [31:0] rd;
        logic        err;
        logic        irq;
        logic        rst;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b1,12'h008,32'd100,       64'd0,    32'd0,    1'b0,1'b0,1'b0}, // R3 R11
        '{1'b1,1'b1,12'h000,32'd1,         64'd1000, 32'd0,    1'b0,1'b0,1'b0}, // R2 enable
        '{1'b1,1'b0,12'h010,32'd0,         64'd1000, 32'd1100, 1'b0,1'b0,1'b0}, // R4
        '{1'b1,1'b0,12'h000,32'd0,         64'd1099, 32'd1,    1'b0,1'b0,1'b0}, // R7 not yet
        '{1'b1,1'b0,12'h000,32'd0,         64'd1100, 32'd1,    1'b0,1'b1,1'b0}, // R7 fires
        '{1'b1,1'b0,12'h000,32'd0,         64'd1150, 32'd3,    1'b0,1'b1,1'b0}, // R7 status
        '{1'b1,1'b0,12'h010,32'd0,         64'd1150, 32'd1200, 1'b0,1'b1,1'b0}, // R7 rearm
        '{1'b0,1'b1,12'h000,32'hDEAD,      64'd1150, 32'd0,    1'b0,1'b0,1'b0}, // R5 kick
        '{1'b1,1'b0,12'h010,32'd0,         64'd1160, 32'd1250, 1'b0,1'b0,1'b0}, // R5 reload
        '{1'b0,1'b0,12'h000,32'd0,         64'd1160, 32'd0,    1'b0,1'b0,1'b0}, // R5 read zero
        '{1'b0,1'b0,12'h0FC,32'd0,         64'd1160, ID,       1'b0,1'b0,1'b0}, // R9
        '{1'b1,1'b0,12'h0FC,32'd0,         64'd1160, ID,       1'b0,1'b0,1'b0}, // R9
        '{1'b1,1'b0,12'h040,32'd0,         64'd1160, 32'd0,    1'b1,1'b0,1'b0}, // R10
        '{1'b1,1'b1,12'h002,32'd0,         64'd1160, 32'd0,    1'b1,1'b0,1'b0}, // R10
        '{1'b0,1'b1,12'h004,32'd0,         64'd1160, 32'd0,    1'b1,1'b0,1'b0}, // R10
        '{1'b0,1'b1,12'h000,32'd0,         64'd1250, 32'd0,    1'b0,1'b0,1'b0}, // R12 priority
        '{1'b1,1'b0,12'h000,32'd0,         64'd1349, 32'd1,    1'b0,1'b0,1'b0}, // R10 no effect
        '{1'b1,1'b0,12'h000,32'd0,         64'd1350, 32'd1,    1'b0,1'b1,1'b0}, // R7
        '{1'b1,1'b0,12'h000,32'd0,         64'd1449, 32'd3,    1'b0,1'b1,1'b0}, // R12 hold
        '{1'b1,1'b0,12'h000,32'd0,         64'd1450, 32'd3,    1'b0,1'b1,1'b1}, // R8
        '{1'b1,1'b0,12'h000,32'd0,         64'd1500, 32'd7,    1'b0,1'b1,1'b1}, // R8 status
        '{1'b1,1'b1,12'h00C,32'hFFFF0002,  64'd2000, 32'd0,    1'b0,1'b0,1'b0}, // R6
        '{1'b1,1'b0,12'h00C,32'd0,         64'd2000, 32'd2,    1'b0,1'b0,1'b0}, // R3 mask
        '{1'b1,1'b0,12'h014,32'd0,         64'd2000, 32'd2,    1'b0,1'b0,1'b0}, // R3 R4
        '{1'b1,1'b0,12'h010,32'd0,         64'd2000, 32'h834,  1'b0,1'b0,1'b0}, // R4
        '{1'b1,1'b1,12'h000,32'd0,         64'd3000, 32'd0,    1'b0,1'b0,1'b0}, // R11 disable
        '{1'b1,1'b0,12'h000,32'd0,         64'hFFFF_FFFF_FFFF_FFFF, 32'd0, 1'b0,1'b0,1'b0}, // R11
        '{1'b1,1'b1,12'h010,32'd5,         64'd3000, 32'd0,    1'b0,1'b0,1'b0}, // R4 cmp write
        '{1'b1,1'b0,12'h010,32'd0,         64'd3000, 32'd5,    1'b0,1'b0,1'b0}  // R4
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] sys_cnt = '0;
    logic        rf_sel = 1'b0, rf_wr = 1'b0, cf_sel = 1'b0, cf_wr = 1'b0;
    logic [11:0] rf_addr = '0, cf_addr = '0;
    logic [31:0] rf_wdata = '0, cf_wdata = '0;
    logic [31:0] rf_rdata, cf_rdata;
    logic        rf_err, cf_err, irq, rst_req;
    int          total = 0, bad = 0;
    logic        done = 1'b0;

    always #10 clk = ~clk;

    wdg_top u_dut (
        .clk(clk), .rst_n(rst_n), .sys_cnt(sys_cnt),
        .rf_sel(rf_sel), .rf_wr(rf_wr), .rf_addr(rf_addr), .rf_wdata(rf_wdata),
        .rf_rdata(rf_rdata), .rf_err(rf_err),
        .cf_sel(cf_sel), .cf_wr(cf_wr), .cf_addr(cf_addr), .cf_wdata(cf_wdata),
        .cf_rdata(cf_rdata), .cf_err(cf_err), .irq(irq), .rst_req(rst_req)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic acc(logic cf, logic wr, logic [11:0] a, logic [31:0] d, logic [63:0] c);
        sys_cnt = c;
        cf_sel = cf;  rf_sel = !cf;
        cf_wr = wr;   rf_wr = wr;
        cf_addr = a;  rf_addr = a;
        cf_wdata = d; rf_wdata = d;
        #1;
    endtask

    task automatic edge_step();
        @(posedge clk);
        @(negedge clk);
        cf_sel = 1'b0; rf_sel = 1'b0;
    endtask

    task automatic rd_chk(string req, logic cf, logic [11:0] a, logic [63:0] c, logic [31:0] exp);
        acc(cf, 1'b0, a, 32'd0, c);
        chk(req, cf ? cf_rdata : rf_rdata, exp);
        edge_step();
    endtask

    task automatic wr_do(logic cf, logic [11:0] a, logic [31:0] d, logic [63:0] c);
        acc(cf, 1'b1, a, d, c);
        edge_step();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 irq", irq, 0);
        chk("R1 rst_req", rst_req, 0);
        rd_chk("R1 ctrl", 1'b1, 12'h000, 64'd0, 32'd0);
        rd_chk("R1 offlo", 1'b1, 12'h008, 64'd0, 32'd0);
        rd_chk("R1 offhi", 1'b1, 12'h00C, 64'd0, 32'd0);
        rd_chk("R1 cmplo", 1'b1, 12'h010, 64'd0, 32'd0);
        rd_chk("R1 cmphi", 1'b1, 12'h014, 64'd0, 32'd0);
        rd_chk("R1 id", 1'b1, 12'h0FC, 64'd0, ID);

        for (int i = 0; i < NV; i++) begin
            acc(VECS[i].cf, VECS[i].wr, VECS[i].addr, VECS[i].data, VECS[i].cnt);
            chk($sformatf("vec%0d rdata", i), VECS[i].cf ? cf_rdata : rf_rdata, VECS[i].rd);
            chk($sformatf("vec%0d err", i), VECS[i].cf ? cf_err : rf_err, VECS[i].err);
            edge_step();
            chk($sformatf("vec%0d irq", i), irq, VECS[i].irq);
            chk($sformatf("vec%0d rst_req", i), rst_req, VECS[i].rst);
        end

        // R2 only bit 0 of control is stored
        wr_do(1'b1, 12'h000, 32'hFFFF_FFFE, 64'd10);
        rd_chk("R2 only bit0", 1'b1, 12'h000, 64'd10, 32'd0);
        // R4 refresh while disabled leaves compare alone
        wr_do(1'b0, 12'h000, 32'h1234, 64'd10);
        rd_chk("R4 disabled refresh", 1'b1, 12'h010, 64'd10, 32'd5);
        chk("R11 irq after kick", irq, 0);
        // R2 status bits in write data ignored; enable loads compare
        wr_do(1'b1, 12'h000, 32'h7, 64'd10);
        rd_chk("R2 ctrl read", 1'b1, 12'h000, 64'd10, 32'd1);
        rd_chk("R4 cmplo", 1'b1, 12'h010, 64'd10, 32'h6E);
        rd_chk("R4 cmphi", 1'b1, 12'h014, 64'd10, 32'd2);
        // R2 control write clears first-stage flag
        wr_do(1'b1, 12'h008, 32'd4, 64'd20);
        rd_chk("R7 arm", 1'b1, 12'h000, 64'd23, 32'd1);
        wr_do(1'b1, 12'h00C, 32'd0, 64'd20);
        rd_chk("R7 first", 1'b1, 12'h000, 64'd24, 32'd1);
        chk("R7 irq", irq, 1);
        wr_do(1'b1, 12'h000, 32'd1, 64'd30);
        chk("R2 ctrl drops irq", irq, 0);
        rd_chk("R2 status cleared", 1'b1, 12'h000, 64'd30, 32'd1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule